// File: doc/BRIEF.md
# Parallel-Bus Converter Sequencer

This block sits in the host and runs single conversions on a 10-bit converter that shares one 8-bit bus for commands and data. When `start` is accepted, it captures the channel number, the input configuration, the polarity, the acquisition style and the clock source. It packs these into a command byte and writes that byte with chip-select and a write strobe. It then waits for the converter's active-low completion line. After that it reads the result in two bytes, low byte first and high byte second, and switches between them with a byte-select output.

The result is returned both as a raw 10-bit code and as a 16-bit value. In bipolar mode the 16-bit value is sign-extended and in unipolar mode it is zero-extended. A one-cycle `valid` pulse marks it. For a fixed period after reset, start requests are held off. A stalled conversion is abandoned after a time limit. When the external clock source is selected, the block also produces the converter's conversion clock by dividing down its own clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The command byte is {1, clock-select, acq-select, single-ended, unipolar, chan[2:0]} from bit 7 down to bit 0. Bits 7:6 are 2'b11 when `ext_clk`=1 and 2'b10 when `ext_clk`=0. Bit 5 is `ext_acq`, bit 4 is `single_ended`, bit 3 is `unipolar` and bits 2:0 are `chan`.
- R2: A write cycle keeps `cs_n` low and drives the byte for TURN_CYC cycles first. `wr_n` is then low for exactly STROBE_CYC cycles, and the byte is held for TURN_CYC cycles after that. Each transaction produces exactly one `wr_n` pulse.
- R3: `bus_oe` is 1 only during the write cycle, which includes every cycle in which `wr_n` is low. `wr_n` and `rd_n` are never low in the same cycle.
- R4: After the completion line falls, there are two `rd_n` pulses of STROBE_CYC cycles each. The first has `hben`=0 and the second has `hben`=1.
- R5: `result` = {high byte bits 1:0, low byte}. `result_ext` is `result` zero-extended when `unipolar`=1 and sign-extended from bit 9 when `unipolar`=0.
- R6: `valid` is high for exactly one cycle, 3+2*(STROBE_CYC+TURN_CYC) cycles after `int_n` falls. The first two of those cycles are taken by a 2-stage synchronizer.
- R7: `busy` is high from the cycle after an accepted start until the cycle after `valid`. Start requests while `busy` is high are ignored.
- R8: Start requests in the first POR_CYC cycles after reset are ignored.
- R9: If `int_n` does not fall within TIMEOUT_CYC cycles of waiting, `timeout_err` is set and the block returns to idle. The flag clears at the next accepted start.
- R10: `conv_clk` toggles every CLK_HALF cycles while the clock source last selected is external. The external source is the value after reset. When the internal source is selected, `conv_clk` stays low. CLK_HALF is clamped so that the output frequency stays between 100 kHz and 4.8 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request |
| chan | input | 3 | Channel address |
| single_ended | input | 1 | 1 = single-ended input, 0 = pseudo-differential input |
| unipolar | input | 1 | 1 = unipolar binary result, 0 = bipolar two's complement result |
| ext_acq | input | 1 | Selects the externally timed acquisition |
| ext_clk | input | 1 | 1 = external conversion clock, 0 = internal conversion clock |
| int_n | input | 1 | Converter completion line, active low |
| bus_in | input | 8 | Data read from the shared bus |
| bus_out | output | 8 | Command byte driven onto the bus |
| bus_oe | output | 1 | Bus driver enable |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | Byte select: 0 = low byte, 1 = high byte |
| conv_clk | output | 1 | Divided conversion clock |
| busy | output | 1 | Transaction in progress |
| valid | output | 1 | One-cycle result strobe |
| result | output | 10 | Raw conversion code |
| result_ext | output | 16 | Extended result |
| timeout_err | output | 1 | Completion line never arrived |

## Verification
Each result arrives a fixed number of cycles after its cause. `busy` rises one cycle after the accepted start. `valid`, `result` and `result_ext` appear nine cycles after `int_n` falls at the default strobe and turnaround values. `busy` falls one cycle after `valid`. The bench drives `int_n` at a falling clock edge and counts the rising edges up to the first falling edge at which `valid` is seen, and it compares that count with the formula. All outputs are sampled on falling edges, half a cycle after the registers update. Strobe widths, the order of the byte-select values, the power-on window and the timeout are measured in whole cycles by monitors that run on that same falling edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SETUP,
        S_WR_PULSE,
        S_WAIT_INT,
        S_RD_LO,
        S_RD_HI,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic       clk_ext;
        logic       acq_ext;
        logic       single;
        logic       unipolar;
        logic [2:0] chan;
    } conv_req_t;

    // command byte: clock-source pair, acquisition, input mode, polarity, address
    function automatic logic [7:0] make_cmd(input conv_req_t r);
        return {1'b1, r.clk_ext, r.acq_ext, r.single, r.unipolar, r.chan};
    endfunction

    function automatic logic [15:0] widen(input logic [9:0] code, input logic uni);
        return uni ? {6'b0, code} : {{6{code[9]}}, code};
    endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int SYS_HZ   = 50_000_000,
    parameter int CLK_HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic clk_o
);
    localparam int FMAX     = 4_800_000;
    localparam int FMIN     = 100_000;
    localparam int HALF_MIN = (SYS_HZ + 2 * FMAX - 1) / (2 * FMAX);
    localparam int HALF_MAX = SYS_HZ / (2 * FMIN);
    localparam int HALF_EFF = (CLK_HALF < HALF_MIN) ? HALF_MIN :
                              (CLK_HALF > HALF_MAX) ? HALF_MAX : CLK_HALF;
    localparam int CW       = $clog2(HALF_EFF + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            clk_o <= 1'b0;
        end else if (cnt == CW'(HALF_EFF - 1)) begin
            cnt   <= '0;
            clk_o <= ~clk_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !clk_o);

endmodule

// File: rtl/adc_seq_pack.sv
module adc_seq_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [7:0]  lo_byte,
    input  logic [1:0]  hi_bits,
    input  logic        uni,
    output logic [9:0]  code,
    output logic [15:0] code_ext
);
    import adc_seq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            code     <= '0;
            code_ext <= '0;
        end else if (load) begin
            code     <= {hi_bits, lo_byte};
            code_ext <= widen({hi_bits, lo_byte}, uni);
        end
    end

    // R5
    pack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(code) && $stable(code_ext));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
    parameter int POR_CYC     = 500,
    parameter int STROBE_CYC  = 2,
    parameter int TURN_CYC    = 1,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  adc_seq_pkg::conv_req_t req_in,
    input  logic                   int_n,
    input  logic [7:0]             bus_in,
    output logic [7:0]             bus_out,
    output logic                   bus_oe,
    output logic                   cs_n,
    output logic                   wr_n,
    output logic                   rd_n,
    output logic                   hben,
    output logic                   busy,
    output logic                   valid,
    output logic                   clk_ext,
    output logic                   uni_q,
    output logic                   hi_load,
    output logic [7:0]             lo_q,
    output logic                   timeout_err
);
    import adc_seq_pkg::*;

    localparam int PHASE = STROBE_CYC + TURN_CYC;
    localparam int CMAX  = (TIMEOUT_CYC > PHASE) ? TIMEOUT_CYC : PHASE;
    localparam int CW    = $clog2(CMAX + 1);
    localparam int PW    = $clog2(POR_CYC + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [PW-1:0] por_cnt;
    logic          por_done;
    logic [1:0]    int_sync;
    conv_req_t     req_q;

    assign por_done = (por_cnt == PW'(POR_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            cnt         <= '0;
            por_cnt     <= '0;
            int_sync    <= 2'b11;
            req_q       <= '{clk_ext: 1'b1, default: '0};
            lo_q        <= '0;
            timeout_err <= 1'b0;
        end else begin
            int_sync <= {int_sync[0], int_n};
            if (!por_done) por_cnt <= por_cnt + 1'b1;
            case (state)
                S_IDLE: begin
                    cnt <= '0;
                    if (start && por_done) begin
                        req_q       <= req_in;
                        timeout_err <= 1'b0;
                        state       <= S_WR_SETUP;
                    end
                end
                S_WR_SETUP: begin
                    if (cnt == CW'(TURN_CYC - 1)) begin
                        cnt <= '0; state <= S_WR_PULSE;
                    end else cnt <= cnt + 1'b1;
                end
                S_WR_PULSE: begin
                    if (cnt == CW'(PHASE - 1)) begin
                        cnt <= '0; state <= S_WAIT_INT;
                    end else cnt <= cnt + 1'b1;
                end
                S_WAIT_INT: begin
                    if (!int_sync[1]) begin
                        cnt <= '0; state <= S_RD_LO;
                    end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
                        cnt <= '0; state <= S_IDLE; timeout_err <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                S_RD_LO: begin
                    if (cnt == CW'(STROBE_CYC - 1)) lo_q <= bus_in;
                    if (cnt == CW'(PHASE - 1)) begin
                        cnt <= '0; state <= S_RD_HI;
                    end else cnt <= cnt + 1'b1;
                end
                S_RD_HI: begin
                    if (cnt == CW'(PHASE - 1)) begin
                        cnt <= '0; state <= S_DONE;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    cnt   <= '0;
                    state <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        bus_oe  = (state == S_WR_SETUP) || (state == S_WR_PULSE);
        cs_n    = !(bus_oe || state == S_RD_LO || state == S_RD_HI);
        wr_n    = !(state == S_WR_PULSE && cnt < CW'(STROBE_CYC));
        rd_n    = !((state == S_RD_LO || state == S_RD_HI) && cnt < CW'(STROBE_CYC));
        hben    = (state == S_RD_HI);
        hi_load = (state == S_RD_HI) && (cnt == CW'(STROBE_CYC - 1));
        bus_out = bus_oe ? make_cmd(req_q) : 8'h00;
        busy    = (state != S_IDLE);
        valid   = (state == S_DONE);
        clk_ext = req_q.clk_ext;
        uni_q   = req_q.unipolar;
    end

    // R3
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!cs_n && rd_n));
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (rd_n && bus_oe));
    // R8
    por_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !por_done |-> !busy);
    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid && !busy);
    // R9
    timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> !busy && cs_n);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int SYS_HZ      = 50_000_000,
    parameter int POR_CYC     = 500,
    parameter int STROBE_CYC  = 2,
    parameter int TURN_CYC    = 1,
    parameter int TIMEOUT_CYC = 1000,
    parameter int CLK_HALF    = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  chan,
    input  logic        single_ended,
    input  logic        unipolar,
    input  logic        ext_acq,
    input  logic        ext_clk,
    input  logic        int_n,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    output logic        cs_n,
    output logic        wr_n,
    output logic        rd_n,
    output logic        hben,
    output logic        conv_clk,
    output logic        busy,
    output logic        valid,
    output logic [9:0]  result,
    output logic [15:0] result_ext,
    output logic        timeout_err
);
    import adc_seq_pkg::*;

    conv_req_t  req;
    logic       clk_sel;
    logic       uni_sel;
    logic       hi_load;
    logic [7:0] lo_byte;

    assign req = '{clk_ext: ext_clk, acq_ext: ext_acq, single: single_ended,
                   unipolar: unipolar, chan: chan};

    adc_seq_fsm #(
        .POR_CYC(POR_CYC), .STROBE_CYC(STROBE_CYC),
        .TURN_CYC(TURN_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .req_in(req), .int_n(int_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .cs_n(cs_n),
        .wr_n(wr_n), .rd_n(rd_n), .hben(hben), .busy(busy), .valid(valid),
        .clk_ext(clk_sel), .uni_q(uni_sel), .hi_load(hi_load), .lo_q(lo_byte),
        .timeout_err(timeout_err)
    );

    adc_seq_pack u_pack (
        .clk(clk), .rst(rst), .load(hi_load), .lo_byte(lo_byte),
        .hi_bits(bus_in[1:0]), .uni(uni_sel), .code(result), .code_ext(result_ext)
    );

    adc_seq_clkdiv #(.SYS_HZ(SYS_HZ), .CLK_HALF(CLK_HALF)) u_div (
        .clk(clk), .rst(rst), .en(clk_sel), .clk_o(conv_clk)
    );

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int POR  = 500;
    localparam int STB  = 2;
    localparam int TRN  = 1;
    localparam int TMO  = 1000;
    localparam int HALF = 10;
    localparam int LAT  = 3 + 2 * (STB + TRN);
    localparam int NV   = 6;

    // {chan, single, uni, acq, extclk, raw[9:0], cmd[7:0], ext[15:0]}
    localparam logic [40:0] VEC [NV] = '{
        {3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 8'hD8, 16'h0000},
        {3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 10'h3FF, 8'hA5, 16'hFFFF},
        {3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 10'h200, 8'hD7, 16'hFE00},
        {3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 10'h1FF, 8'hEA, 16'h01FF},
        {3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 10'h155, 8'hB3, 16'h0155},
        {3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 10'h2AA, 8'h8E, 16'h02AA}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [2:0] chan = '0;
    logic single_ended = 1'b0, unipolar = 1'b0, ext_acq = 1'b0, ext_clk = 1'b0;
    logic int_n = 1'b1;
    logic [7:0] bus_in, bus_out;
    logic bus_oe, cs_n, wr_n, rd_n, hben, conv_clk, busy, valid, timeout_err;
    logic [9:0] result;
    logic [15:0] result_ext;

    logic [9:0] adc_raw = '0;
    logic       adc_bip = 1'b0;
    int vectors = 0, fails = 0;

    int wr_falls = 0, wr_low = 0, oe_bad = 0, rd_falls = 0;
    logic [7:0] cap_cmd = '0;
    logic [1:0] hb_hist = '0;
    logic wr_prev = 1'b1, rd_prev = 1'b1;

    always #10 clk = ~clk;

    always_comb begin
        if (!cs_n && !rd_n)
            bus_in = hben ? {{6{adc_bip & adc_raw[9]}}, adc_raw[9:8]} : adc_raw[7:0];
        else
            bus_in = 8'h3C;
    end

    adc_seq_ctrl #(.POR_CYC(POR), .STROBE_CYC(STB), .TURN_CYC(TRN),
                   .TIMEOUT_CYC(TMO), .CLK_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .single_ended(single_ended),
        .unipolar(unipolar), .ext_acq(ext_acq), .ext_clk(ext_clk), .int_n(int_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .hben(hben), .conv_clk(conv_clk), .busy(busy), .valid(valid),
        .result(result), .result_ext(result_ext), .timeout_err(timeout_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (!wr_n) begin
                wr_low  = wr_low + 1;
                cap_cmd = bus_out;
                if (!bus_oe) oe_bad = oe_bad + 1;
                if (wr_prev) wr_falls = wr_falls + 1;
            end
            if (!rd_n && rd_prev) begin
                rd_falls = rd_falls + 1;
                hb_hist  = {hb_hist[0], hben};
            end
            wr_prev = wr_n;
            rd_prev = rd_n;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic count_toggles(input int n, output int t);
        logic last;
        t = 0;
        last = conv_clk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_clk !== last) t++;
            last = conv_clk;
        end
    endtask

    task automatic run_vec(input logic [40:0] v, input int dly, input logic inject);
        int wf0, wl0, ob0, rf0, k, g;
        wf0 = wr_falls; wl0 = wr_low; ob0 = oe_bad; rf0 = rd_falls;
        @(negedge clk);
        {chan, single_ended, unipolar, ext_acq, ext_clk} = v[40:34];
        adc_raw = v[33:24];
        adc_bip = !v[38];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", busy, 1);
        chk("R9 err cleared by start", timeout_err, 0);
        g = 0;
        while ((wr_falls == wf0 || !wr_n) && g < 50) begin @(negedge clk); g++; end
        if (inject) begin
            chan = ~chan; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        repeat (dly) @(negedge clk);
        int_n = 1'b0;
        k = 0;
        while (k < 40) begin
            @(negedge clk);
            k++;
            if (!rd_n) int_n = 1'b1;
            if (valid) break;
        end
        chk("R6 valid latency", k, LAT);
        chk("R5 result", result, v[33:24]);
        chk("R5 result_ext", result_ext, v[15:0]);
        chk("R1 command byte", cap_cmd, v[23:16]);
        chk("R2 wr_n low width", wr_low - wl0, STB);
        chk("R2 R7 single write pulse", wr_falls - wf0, 1);
        chk("R3 bus driven while wr_n low", oe_bad - ob0, 0);
        chk("R4 two read strobes", rd_falls - rf0, 2);
        chk("R4 hben order", hb_hist, 2'b01);
        @(negedge clk);
        chk("R6 valid one cycle", valid, 0);
        chk("R7 busy dropped", busy, 0);
    endtask

    initial begin
        int t, bh;
        repeat (5) @(negedge clk);
        chk("R3 reset bus_oe", bus_oe, 0);
        chk("R2 reset cs_n", cs_n, 1);
        chk("R2 reset wr_n", wr_n, 1);
        chk("R4 reset rd_n", rd_n, 1);
        chk("R7 reset busy", busy, 0);
        chk("R6 reset valid", valid, 0);
        chk("R9 reset err", timeout_err, 0);
        rst = 1'b0;
        start = 1'b1;
        bh = 0; t = 0;
        begin
            logic last;
            last = conv_clk;
            for (int i = 0; i < POR - 20; i++) begin
                @(negedge clk);
                if (busy || !cs_n) bh++;
                if (i < 20 * HALF && conv_clk !== last) t++;
                last = conv_clk;
            end
        end
        start = 1'b0;
        chk("R8 start ignored after reset", bh, 0);
        chk("R10 external clock after reset", t, 20);
        repeat (40) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 2 * i + 1, i == 2);

        count_toggles(6 * HALF, t);
        chk("R10 internal clock keeps conv_clk still", t, 0);
        chk("R10 internal clock level", conv_clk, 0);

        @(negedge clk);
        chan = 3'd1; ext_clk = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (TMO / 2) @(negedge clk);
        chk("R9 no early timeout", timeout_err, 0);
        chk("R9 still waiting", busy, 1);
        repeat (TMO) @(negedge clk);
        chk("R9 timeout flag", timeout_err, 1);
        chk("R9 idle after timeout", busy, 0);
        chk("R9 bus deselected", cs_n, 1);

        run_vec(VEC[0], 4, 1'b0);
        count_toggles(20 * HALF, t);
        chk("R10 external clock period", t, 20);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule